// File: doc/BRIEF.md
# Sixteen-bit timer/counter with overflow toggle output

This block is a 16-bit up-counter that advances either on every machine cycle (timer use) or on every falling edge of an external event input (counter use). The chip supplies a one-clock machine-cycle strobe. The event input is looked at only in strobe cycles. A fall is recognised when the value seen in one strobe cycle is 1 and the value seen in the next strobe cycle is 0.

Three counting layouts are available:

- A 13-bit layout: a 5-bit prescaler below an 8-bit high byte.
- A full 16-bit layout.
- An 8-bit layout in which the low byte reloads from the high byte.

A fourth mode code freezes the count. On every wrap or reload a sticky overflow flag is raised. When enabled, a toggle pin inverts on each overflow.

Software can load the whole count at any time and can clear the flag through dedicated strobes.

Top module: `tmr_evt_top`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0x0000, `ovf_flag` becomes 0 and `tog_out` becomes 0.
- R2: With `cnt_sel`=0, `run`=1 and mode 1, `count` increases by one after each clock edge at which `mc_en`=1, and it never changes at an edge where `mc_en`=0 and `wr_en`=0.
- R3: With `cnt_sel`=1, an increment happens at a strobe edge only if the `ext_in` value captured at the previous strobe was 1 and `ext_in` is 0 now. Activity on `ext_in` between strobes has no effect.
- R4: With `run`=0 and `wr_en`=0, `count` holds its value.
- R5: Mode code 0 (13-bit): bits [4:0] form the prescaler and carry into bits [15:8]. Bits [7:5] never change on an increment. The count wraps, with overflow, when bits [15:8]=0xFF and bits [4:0]=0x1F.
- R6: Mode code 1 (16-bit): the count wraps from 0xFFFF to 0x0000 and raises `ovf_flag` at that edge.
- R7: Mode code 2 (reload): bits [7:0] count. When they are 0xFF, the next increment loads them from bits [15:8] and raises `ovf_flag`. Bits [15:8] never change on an increment.
- R8: Mode code 3 leaves `count` unchanged except for writes.
- R9: `ovf_flag` stays set until a clock edge with `flag_clr`=1 and no overflow. If an overflow and `flag_clr` occur at the same edge, the flag ends up set.
- R10: `tog_out` inverts at each overflow edge when `tog_en`=1. When `tog_en`=0 it does not change.
- R11: `wr_en`=1 loads `count` with `wr_data` and cancels any increment and overflow at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle strobe, one clock wide |
| ext_in | input | 1 | External event input |
| run | input | 1 | Counting enabled when 1 |
| cnt_sel | input | 1 | 1 = count events, 0 = count machine cycles |
| mode | input | 2 | 0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = frozen |
| tog_en | input | 1 | Enables inversion of `tog_out` on overflow |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 16 | Value to load, high byte in [15:8] |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Current count, high byte in [15:8] |
| ovf_flag | output | 1 | Sticky overflow flag |
| tog_out | output | 1 | Overflow toggle pin |

## Verification
The embedded assertions check the following on every cycle:

- Freezing when `run` is low, and with mode 3.
- No movement without a strobe.
- Write priority.
- The fixed high byte in reload mode and the fixed middle bits in 13-bit mode.
- Flag persistence and flag setting on every wrap.
- Toggle-pin stability when toggling is disabled.

Only the bench's scenarios can show the following:

- Exact increment arithmetic.
- Wrap points in each layout.
- Falling-edge detection on strobe-sampled values.
- A pulse hidden between two strobes being ignored.
- The clear-versus-overflow tie.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    localparam int HALF_W  = 8;
    localparam int PRESC_W = 5;
    localparam int CNT_W   = 2 * HALF_W;
    localparam int M13_W   = HALF_W + PRESC_W;

    typedef enum logic [1:0] {
        MD_13BIT  = 2'd0,
        MD_16BIT  = 2'd1,
        MD_RELOAD = 2'd2,
        MD_FROZEN = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tmr_cnt_t;

    typedef struct packed {
        tmr_cnt_t cnt;
        logic     wrap;
    } tmr_step_t;

    function automatic tmr_step_t step_13(input tmr_cnt_t c);
        tmr_step_t r;
        logic [M13_W:0] v;
        v      = {1'b0, c.hi, c.lo[PRESC_W-1:0]} + {{M13_W{1'b0}}, 1'b1};
        r.cnt.hi = v[M13_W-1:PRESC_W];
        r.cnt.lo = {c.lo[HALF_W-1:PRESC_W], v[PRESC_W-1:0]};
        r.wrap   = v[M13_W];
        return r;
    endfunction

    function automatic tmr_step_t step_16(input tmr_cnt_t c);
        tmr_step_t r;
        logic [CNT_W:0] v;
        v      = {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
        r.cnt  = v[CNT_W-1:0];
        r.wrap = v[CNT_W];
        return r;
    endfunction

    function automatic tmr_step_t step_reload(input tmr_cnt_t c);
        tmr_step_t r;
        r.cnt.hi = c.hi;
        if (&c.lo) begin
            r.cnt.lo = c.hi;
            r.wrap   = 1'b1;
        end else begin
            r.cnt.lo = c.lo + {{(HALF_W-1){1'b0}}, 1'b1};
            r.wrap   = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_evt_sampler.sv
module tmr_evt_sampler (
    input  logic clk,
    input  logic rst,
    input  logic mc_en,
    input  logic ext_in,
    input  logic run,
    input  logic cnt_sel,
    output logic tick
);
    logic smp_q;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst)        smp_q <= 1'b0;
        else if (mc_en) smp_q <= ext_in;
    end

    assign fall = smp_q & ~ext_in;
    assign tick = mc_en & run & (cnt_sel ? fall : 1'b1);

endmodule

// File: rtl/tmr_evt_core.sv
module tmr_evt_core
    import tmr_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  tmr_mode_e mode,
    input  logic      wr_en,
    input  tmr_cnt_t  wr_data,
    output tmr_cnt_t  cnt_q,
    output logic      wrap
);
    tmr_step_t nxt;

    always_comb begin
        nxt.cnt  = cnt_q;
        nxt.wrap = 1'b0;
        if (wr_en) begin
            nxt.cnt = wr_data;
        end else if (tick) begin
            unique case (mode)
                MD_13BIT:  nxt = step_13(cnt_q);
                MD_16BIT:  nxt = step_16(cnt_q);
                MD_RELOAD: nxt = step_reload(cnt_q);
                default:   nxt = '{cnt: cnt_q, wrap: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt.cnt;
    end

    assign wrap = nxt.wrap;

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_data));

    assert_frozen_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_FROZEN) && !wr_en |=> $stable(cnt_q));

    assert_reload_hi_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RELOAD) && !wr_en |=> $stable(cnt_q.hi));

    assert_mid_bits_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_13BIT) && !wr_en |=> $stable(cnt_q.lo[HALF_W-1:PRESC_W]));

endmodule

// File: rtl/tmr_evt_ovf.sv
module tmr_evt_ovf (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic flag_clr,
    input  logic tog_en,
    output logic flag_q,
    output logic tog_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            if (wrap)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (wrap && tog_en) tog_q <= ~tog_q;
        end
    end

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        flag_q && !flag_clr |=> flag_q);

    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q);

    assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !tog_en |=> $stable(tog_q));

endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
    import tmr_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mc_en,
    input  logic        ext_in,
    input  logic        run,
    input  logic        cnt_sel,
    input  logic [1:0]  mode,
    input  logic        tog_en,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        flag_clr,
    output logic [15:0] count,
    output logic        ovf_flag,
    output logic        tog_out
);
    logic     tick;
    logic     wrap;
    tmr_cnt_t cnt_q;

    tmr_evt_sampler u_smp (
        .clk     (clk),
        .rst     (rst),
        .mc_en   (mc_en),
        .ext_in  (ext_in),
        .run     (run),
        .cnt_sel (cnt_sel),
        .tick    (tick)
    );

    tmr_evt_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (tmr_mode_e'(mode)),
        .wr_en   (wr_en),
        .wr_data (tmr_cnt_t'(wr_data)),
        .cnt_q   (cnt_q),
        .wrap    (wrap)
    );

    tmr_evt_ovf u_ovf (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .flag_clr (flag_clr),
        .tog_en   (tog_en),
        .flag_q   (ovf_flag),
        .tog_q    (tog_out)
    );

    assign count = cnt_q;

    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        !run && !wr_en |=> $stable(count));

    assert_no_strobe_no_move_R2: assert property (@(posedge clk) disable iff (rst)
        !mc_en && !wr_en |=> $stable(count));

endmodule

// File: tb/tb_tmr_evt_top.sv
module tb_tmr_evt_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mc_en = 0, ext_in = 0, run = 0, cnt_sel = 0, tog_en = 0, wr_en = 0, flag_clr = 0;
    logic [1:0]  mode = 2'd1;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        ovf_flag, tog_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0;
    bit m_flag = 0, m_tog = 0, m_smp = 0;

    tmr_evt_top dut (
        .clk(clk), .rst(rst), .mc_en(mc_en), .ext_in(ext_in), .run(run),
        .cnt_sel(cnt_sel), .mode(mode), .tog_en(tog_en), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .count(count),
        .ovf_flag(ovf_flag), .tog_out(tog_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit tk, ov;
        int pre, hi, lo, mid, v;
        if (rst) begin
            m_cnt = 0; m_flag = 0; m_tog = 0; m_smp = 0;
        end else begin
            tk = mc_en && run && (cnt_sel ? (m_smp && !ext_in) : 1'b1);
            ov = 0;
            if (wr_en) m_cnt = int'(wr_data);
            else if (tk) begin
                case (mode)
                    2'd0: begin
                        pre = m_cnt % 32; mid = m_cnt % 256 - pre; hi = m_cnt / 256;
                        v = hi * 32 + pre + 1;
                        if (v == 8192) begin v = 0; ov = 1; end
                        m_cnt = (v / 32) * 256 + mid + (v % 32);
                    end
                    2'd1: begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt == 65536) begin m_cnt = 0; ov = 1; end
                    end
                    2'd2: begin
                        lo = m_cnt % 256; hi = m_cnt / 256;
                        if (lo == 255) begin lo = hi; ov = 1; end
                        else lo = lo + 1;
                        m_cnt = hi * 256 + lo;
                    end
                    default: ;
                endcase
            end
            if (ov) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (ov && tog_en) m_tog = ~m_tog;
            if (mc_en) m_smp = ext_in;
        end
        #2;
        total++;
        if (count !== 16'(m_cnt) || ovf_flag !== m_flag || tog_out !== m_tog) begin
            bad++;
            $display("FAIL %s cycle model: count=%h flag=%b tog=%b expected count=%h flag=%b tog=%b",
                     cur_req, count, ovf_flag, tog_out, 16'(m_cnt), m_flag, m_tog);
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic strobe);
        mc_en = strobe;
        @(negedge clk);
        mc_en = 0;
    endtask

    task automatic load(input logic [15:0] val);
        wr_en = 1; wr_data = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", count, 16'h0000);
        chk("R1", {15'd0, ovf_flag}, 16'd0);
        chk("R1", {15'd0, tog_out}, 16'd0);
        rst = 0;
        @(negedge clk);

        // R2 timer counting of strobes
        cur_req = "R2"; run = 1; mode = 2'd1;
        for (int i = 0; i < 20; i++) cyc(i % 2 == 1);
        chk("R2", count, 16'd10);

        // R4 stopped counter holds
        cur_req = "R4"; run = 0;
        for (int i = 0; i < 10; i++) cyc(1'b1);
        chk("R4", count, 16'd10);

        // R11 write beats increment in the same edge
        cur_req = "R11"; run = 1; mc_en = 1;
        load(16'hFFFE);
        chk("R11", count, 16'hFFFE);

        // R6 wrap, R10 toggle enabled
        cur_req = "R6"; tog_en = 1;
        cyc(1'b1); cyc(1'b1);
        chk("R6", count, 16'h0000);
        chk("R6", {15'd0, ovf_flag}, 16'd1);
        chk("R10", {15'd0, tog_out}, 16'd1);

        // R9 sticky flag, clear, tie
        cur_req = "R9"; tog_en = 0; run = 0;
        for (int i = 0; i < 5; i++) cyc(1'b1);
        chk("R9", {15'd0, ovf_flag}, 16'd1);
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        chk("R9", {15'd0, ovf_flag}, 16'd0);
        run = 1;
        load(16'hFFFF);
        flag_clr = 1; cyc(1'b1); flag_clr = 0;
        chk("R9", {15'd0, ovf_flag}, 16'd1);

        // R10 toggle disabled
        cur_req = "R10";
        load(16'hFFFF); cyc(1'b1);
        chk("R10", {15'd0, tog_out}, 16'd1);

        // R5 13-bit layout
        cur_req = "R5"; mode = 2'd0;
        load(16'hFFFF); cyc(1'b1);
        chk("R5", count, 16'h00E0);
        load(16'h12A3);
        for (int i = 0; i < 29; i++) cyc(1'b1);
        chk("R5", count, 16'h13A0);

        // R7 reload layout
        cur_req = "R7"; mode = 2'd2; tog_en = 1;
        flag_clr = 1; load(16'h40FE); flag_clr = 0;
        cyc(1'b1);
        chk("R7", count, 16'h40FF);
        cyc(1'b1);
        chk("R7", count, 16'h4040);
        chk("R7", {15'd0, ovf_flag}, 16'd1);
        chk("R10", {15'd0, tog_out}, 16'd0);
        tog_en = 0;

        // R8 frozen code
        cur_req = "R8"; mode = 2'd3;
        load(16'h1234);
        for (int i = 0; i < 5; i++) cyc(1'b1);
        chk("R8", count, 16'h1234);

        // R3 event counting
        cur_req = "R3"; mode = 2'd1; cnt_sel = 1;
        load(16'h0000);
        for (int i = 0; i < 6; i++) begin ext_in = (i % 2 == 0); cyc(1'b1); end
        chk("R3", count, 16'd3);
        ext_in = 0; cyc(1'b1);
        for (int i = 0; i < 4; i++) begin
            ext_in = 1; cyc(1'b0);
            ext_in = 0; cyc(1'b0);
            cyc(1'b1);
        end
        chk("R3", count, 16'd3);
        ext_in = 1; cyc(1'b1);
        ext_in = 0; cyc(1'b1);
        chk("R3", count, 16'd4);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule